// File: doc/BRIEF.md
# AXI4 Memory Slave with Response Latency

This block is an AXI4 slave that holds its data in an internal word array. It accepts one incrementing read burst and one incrementing write burst at a time. Each path has its own latency parameter, so a bench or a system model can imitate the delay of a real memory. Every beat of a burst covers the full data width.

The size of the store is set apart from the width of the address ports, so a small array can sit in a wide address space. Addresses arrive as byte addresses. The byte-offset bits are dropped, and the remaining word number is reduced modulo the store depth, so higher addresses alias onto the same words. Exactly one of the two size parameters may be left at zero, and it is then derived from the other.

The read side is a three-state machine:
- RD_IDLE moves to RD_WAIT when an address is accepted, or straight to RD_SEND when the read latency is zero.
- RD_WAIT counts the latency down and moves to RD_SEND when the count reaches one.
- RD_SEND returns to RD_IDLE when the final beat is accepted.

The write side has four states:
- WR_IDLE moves to WR_DATA when an address is accepted.
- WR_DATA moves to WR_WAIT, or to WR_RESP when the write latency is zero, on the closing beat. The closing beat is the one with the last flag, or the one numbered by the burst length, whichever comes first.
- WR_WAIT counts down and moves to WR_RESP.
- WR_RESP returns to WR_IDLE when the response is accepted.

Top module: `axi_lat_mem`

## Requirements
- R1: While reset is held, and directly after it, ar_ready and aw_ready are 1, and r_valid, w_ready and b_valid are 0.
- R2: A read burst of length L returns exactly L+1 beats from consecutive word indices. The word index wraps modulo the depth. r_last is 1 on the final beat only, and r_valid drops after the final beat is accepted.
- R3: The first r_valid appears after exactly RD_LAT idle cycles following the address handshake.
- R4: b_valid appears after exactly WR_LAT idle cycles following the closing write beat, with b_resp equal to 2'b00 (OKAY). w_ready is 0 while b_valid is 1.
- R5: Bit i of w_strb enables writing of data bits [8i+7:8i]. Bytes whose strobe bit is 0 keep their old value.
- R6: Word index = (byte address >> log2(DATA_W/8)) mod depth. The low byte-offset bits are ignored, and addresses that differ by a multiple of depth*DATA_W/8 reach the same word.
- R7: After an address handshake, the ready of that channel stays 0 until its burst completes: the final read beat, or the write response handshake. It is 1 again in the next cycle.
- R8: While r_valid or b_valid is 1 and the matching ready is 0, the valid stays 1 and the read beat's data and last flag stay unchanged.
- R9: r_resp is 2'b00 (OKAY) on every read beat.
- R10: With ADDR_W set to 0, the address width is derived as log2(MEM_WORDS*DATA_W/8). The top byte address of that space reaches the last word.
- R11: With a latency parameter of 0, r_valid or b_valid is 1 in the cycle directly after the address handshake or the closing write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_addr | input | AW | Write burst start byte address |
| aw_len | input | LEN_W | Write beats minus one |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted |
| w_data | input | DATA_W | Write beat data |
| w_strb | input | DATA_W/8 | Byte enables of the write beat |
| w_last | input | 1 | Closing write beat |
| w_valid | input | 1 | Write beat valid |
| w_ready | output | 1 | Write beat accepted |
| b_resp | output | 2 | Write response, always OKAY |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| ar_addr | input | AW | Read burst start byte address |
| ar_len | input | LEN_W | Read beats minus one |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address accepted |
| r_data | output | DATA_W | Read beat data |
| r_resp | output | 2 | Read response, always OKAY |
| r_last | output | 1 | Final read beat |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat taken |

## Verification
The embedded properties check the following on every cycle:
- Both latencies, measured with their own cycle counters.
- The drop of each ready after an address handshake.
- The holding of valid and of the read beat under back-pressure.
- The end of a read burst at its last beat.

Only the bench's scenarios can show:
- That the data read back equals the data written.
- That byte strobes merge correctly.
- That aliased and offset addresses reach the expected word.
- That bursts wrap across the end of the store.
- That a second configuration, with a derived address width and zero latency, behaves as required.

// File: rtl/axi_mem_pkg.sv
package axi_mem_pkg;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {RD_IDLE, RD_WAIT, RD_SEND} rd_state_t;
    typedef enum logic [1:0] {WR_IDLE, WR_DATA, WR_WAIT, WR_RESP} wr_state_t;

    // address width: given, or derived from the store size
    function automatic int addr_bits(int aw, int words, int bytes);
        return (aw > 0) ? aw : $clog2(words * bytes);
    endfunction

    // store depth: given, or derived from the address width
    function automatic int depth_words(int aw, int words, int bytes);
        return (words > 0) ? words : (1 << aw) / bytes;
    endfunction

    function automatic int index_bits(int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction

endpackage

// File: rtl/axi_mem_store.sv
module axi_mem_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 16,
    parameter int IDX_W  = 4
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W/8-1:0]   wr_strb,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_q [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_strb[g]) begin
                lane_q[wr_idx] <= wr_data[8*g +: 8];
            end
        end

        assign rd_data[8*g +: 8] = lane_q[rd_idx];
    end

endmodule

// File: rtl/axi_mem_rd.sv
module axi_mem_rd
    import axi_mem_pkg::*;
#(
    parameter int AW    = 12,
    parameter int LEN_W = 8,
    parameter int IDX_W = 4,
    parameter int OFF_W = 2,
    parameter int LAT   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ar_addr,
    input  logic [LEN_W-1:0] ar_len,
    input  logic             ar_valid,
    output logic             ar_ready,
    output logic             r_valid,
    output logic             r_last,
    output logic [1:0]       r_resp,
    input  logic             r_ready,
    output logic [IDX_W-1:0] rd_idx
);
    localparam int CNT_W = $clog2(LAT + 2);
    localparam logic [CNT_W-1:0] LAT_LOAD = CNT_W'(LAT);

    rd_state_t        state_q, state_n;
    logic [CNT_W-1:0] wait_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q, beat_q;
    logic             accept, final_beat;

    assign accept     = ar_valid && (state_q == RD_IDLE);
    assign final_beat = (beat_q == len_q);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RD_IDLE: if (ar_valid) state_n = (LAT == 0) ? RD_SEND : RD_WAIT;
            RD_WAIT: if (wait_q == CNT_W'(1)) state_n = RD_SEND;
            RD_SEND: if (r_ready && final_beat) state_n = RD_IDLE;
            default: state_n = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
            idx_q  <= '0;
            len_q  <= '0;
            beat_q <= '0;
        end else if (accept) begin
            wait_q <= LAT_LOAD;
            idx_q  <= IDX_W'(ar_addr >> OFF_W);
            len_q  <= ar_len;
            beat_q <= '0;
        end else if (state_q == RD_WAIT) begin
            wait_q <= wait_q - CNT_W'(1);
        end else if (state_q == RD_SEND && r_ready) begin
            idx_q  <= idx_q + IDX_W'(1);
            beat_q <= beat_q + LEN_W'(1);
        end
    end

    always_comb begin
        ar_ready = 1'b0;
        r_valid  = 1'b0;
        r_last   = 1'b0;
        unique case (state_q)
            RD_IDLE: ar_ready = 1'b1;
            RD_SEND: begin
                r_valid = 1'b1;
                r_last  = final_beat;
            end
            default: ;
        endcase
    end

    assign r_resp = RESP_OKAY;
    assign rd_idx = idx_q;

    // cycles since the last address handshake, frozen while a beat is offered
    logic [31:0] since_ar;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   since_ar <= '0;
        else if (ar_valid && ar_ready) since_ar <= '0;
        else if (!r_valid)            since_ar <= since_ar + 32'd1;
    end

    p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_valid) |-> since_ar == 32'(LAT));

    p_rd_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready) |=> !ar_ready);

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_last) && $stable(rd_idx)));

    p_rd_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_ready && r_last) |=> !r_valid);

endmodule

// File: rtl/axi_mem_wr.sv
module axi_mem_wr
    import axi_mem_pkg::*;
#(
    parameter int AW    = 12,
    parameter int LEN_W = 8,
    parameter int IDX_W = 4,
    parameter int OFF_W = 2,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    aw_addr,
    input  logic [LEN_W-1:0] aw_len,
    input  logic             aw_valid,
    output logic             aw_ready,
    input  logic             w_valid,
    input  logic             w_last,
    output logic             w_ready,
    output logic [1:0]       b_resp,
    output logic             b_valid,
    input  logic             b_ready,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx
);
    localparam int CNT_W = $clog2(LAT + 2);
    localparam logic [CNT_W-1:0] LAT_LOAD = CNT_W'(LAT);

    wr_state_t        state_q, state_n;
    logic [CNT_W-1:0] wait_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q, beat_q;
    logic             accept, take_beat, burst_end;

    assign accept    = aw_valid && (state_q == WR_IDLE);
    assign take_beat = w_valid && (state_q == WR_DATA);
    assign burst_end = w_last || (beat_q == len_q);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            WR_IDLE: if (aw_valid) state_n = WR_DATA;
            WR_DATA: if (w_valid && burst_end) state_n = (LAT == 0) ? WR_RESP : WR_WAIT;
            WR_WAIT: if (wait_q == CNT_W'(1)) state_n = WR_RESP;
            WR_RESP: if (b_ready) state_n = WR_IDLE;
            default: state_n = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
            idx_q  <= '0;
            len_q  <= '0;
            beat_q <= '0;
        end else if (accept) begin
            idx_q  <= IDX_W'(aw_addr >> OFF_W);
            len_q  <= aw_len;
            beat_q <= '0;
        end else if (take_beat) begin
            idx_q  <= idx_q + IDX_W'(1);
            beat_q <= beat_q + LEN_W'(1);
            if (burst_end) wait_q <= LAT_LOAD;
        end else if (state_q == WR_WAIT) begin
            wait_q <= wait_q - CNT_W'(1);
        end
    end

    always_comb begin
        aw_ready = 1'b0;
        w_ready  = 1'b0;
        b_valid  = 1'b0;
        unique case (state_q)
            WR_IDLE: aw_ready = 1'b1;
            WR_DATA: w_ready  = 1'b1;
            WR_RESP: b_valid  = 1'b1;
            default: ;
        endcase
    end

    assign b_resp = RESP_OKAY;
    assign wr_en  = take_beat;
    assign wr_idx = idx_q;

    // cycles since the closing data beat, frozen while a response is offered
    logic [31:0] since_wl;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            since_wl <= '0;
        else if (w_valid && w_ready && w_last) since_wl <= '0;
        else if (!b_valid)                     since_wl <= since_wl + 32'd1;
    end

    p_wr_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_valid) |-> since_wl == 32'(LAT));

    p_wr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> !w_ready);

    p_wr_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready) |=> !aw_ready);

    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> b_valid);

endmodule

// File: rtl/axi_lat_mem.sv
module axi_lat_mem
    import axi_mem_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int MEM_WORDS = 16,
    parameter int RD_LAT    = 3,
    parameter int WR_LAT    = 2,
    parameter int LEN_W     = 8,
    localparam int AW       = addr_bits(ADDR_W, MEM_WORDS, DATA_W / 8)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       aw_addr,
    input  logic [LEN_W-1:0]    aw_len,
    input  logic                aw_valid,
    output logic                aw_ready,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [DATA_W/8-1:0] w_strb,
    input  logic                w_last,
    input  logic                w_valid,
    output logic                w_ready,
    output logic [1:0]          b_resp,
    output logic                b_valid,
    input  logic                b_ready,
    input  logic [AW-1:0]       ar_addr,
    input  logic [LEN_W-1:0]    ar_len,
    input  logic                ar_valid,
    output logic                ar_ready,
    output logic [DATA_W-1:0]   r_data,
    output logic [1:0]          r_resp,
    output logic                r_last,
    output logic                r_valid,
    input  logic                r_ready
);
    localparam int WORDS = depth_words(ADDR_W, MEM_WORDS, DATA_W / 8);
    localparam int IDX_W = index_bits(WORDS);
    localparam int OFF_W = $clog2(DATA_W / 8);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    axi_mem_rd #(
        .AW(AW), .LEN_W(LEN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LAT(RD_LAT)
    ) u_rd (
        .clk(clk), .rst_n(rst_n),
        .ar_addr(ar_addr), .ar_len(ar_len), .ar_valid(ar_valid), .ar_ready(ar_ready),
        .r_valid(r_valid), .r_last(r_last), .r_resp(r_resp), .r_ready(r_ready),
        .rd_idx(rd_idx)
    );

    axi_mem_wr #(
        .AW(AW), .LEN_W(LEN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LAT(WR_LAT)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .aw_addr(aw_addr), .aw_len(aw_len), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .w_valid(w_valid), .w_last(w_last), .w_ready(w_ready),
        .b_resp(b_resp), .b_valid(b_valid), .b_ready(b_ready),
        .wr_en(wr_en), .wr_idx(wr_idx)
    );

    axi_mem_store #(
        .DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(w_data), .wr_strb(w_strb),
        .rd_idx(rd_idx), .rd_data(r_data)
    );

endmodule

// File: tb/tb_axi_lat_mem.sv
`timescale 1ns/1ps
module tb_axi_lat_mem;
    localparam int RD_LAT = 3;
    localparam int WR_LAT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [11:0] aw_addr = '0, ar_addr = '0;
    logic [7:0]  aw_len = '0, ar_len = '0;
    logic        aw_valid = 0, w_valid = 0, w_last = 0, b_ready = 0, ar_valid = 0, r_ready = 0;
    logic [31:0] w_data = '0;
    logic [3:0]  w_strb = '0;
    logic        aw_ready, w_ready, b_valid, ar_ready, r_last, r_valid;
    logic [1:0]  b_resp, r_resp;
    logic [31:0] r_data;

    axi_lat_mem #(.DATA_W(32), .ADDR_W(12), .MEM_WORDS(16), .RD_LAT(RD_LAT),
                  .WR_LAT(WR_LAT), .LEN_W(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .aw_addr(aw_addr), .aw_len(aw_len), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .w_data(w_data), .w_strb(w_strb), .w_last(w_last), .w_valid(w_valid), .w_ready(w_ready),
        .b_resp(b_resp), .b_valid(b_valid), .b_ready(b_ready),
        .ar_addr(ar_addr), .ar_len(ar_len), .ar_valid(ar_valid), .ar_ready(ar_ready),
        .r_data(r_data), .r_resp(r_resp), .r_last(r_last), .r_valid(r_valid), .r_ready(r_ready)
    );

    // second configuration: derived address width, zero latency
    logic [5:0]  zaw_addr = '0, zar_addr = '0;
    logic [7:0]  zaw_len = '0, zar_len = '0;
    logic        zaw_valid = 0, zw_valid = 0, zw_last = 0, zb_ready = 0, zar_valid = 0, zr_ready = 0;
    logic [31:0] zw_data = '0;
    logic [3:0]  zw_strb = '0;
    logic        zaw_ready, zw_ready, zb_valid, zar_ready, zr_last, zr_valid;
    logic [1:0]  zb_resp, zr_resp;
    logic [31:0] zr_data;

    axi_lat_mem #(.DATA_W(32), .ADDR_W(0), .MEM_WORDS(16), .RD_LAT(0),
                  .WR_LAT(0), .LEN_W(8)) dut_z (
        .clk(clk), .rst_n(rst_n),
        .aw_addr(zaw_addr), .aw_len(zaw_len), .aw_valid(zaw_valid), .aw_ready(zaw_ready),
        .w_data(zw_data), .w_strb(zw_strb), .w_last(zw_last), .w_valid(zw_valid), .w_ready(zw_ready),
        .b_resp(zb_resp), .b_valid(zb_valid), .b_ready(zb_ready),
        .ar_addr(zar_addr), .ar_len(zar_len), .ar_valid(zar_valid), .ar_ready(zar_ready),
        .r_data(zr_data), .r_resp(zr_resp), .r_last(zr_last), .r_valid(zr_valid), .r_ready(zr_ready)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] got [16];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] addr, input logic [7:0] len,
                            input logic [31:0] seed, input logic [3:0] strb);
        int n;
        @(negedge clk);
        aw_addr = addr; aw_len = len; aw_valid = 1;
        while (!aw_ready) @(negedge clk);
        @(negedge clk);
        aw_valid = 0;
        chk("R7 aw_ready low during burst", 32'(aw_ready), 0);
        for (int b = 0; b <= int'(len); b++) begin
            w_data = seed + 32'(b); w_strb = strb; w_last = (b == int'(len)); w_valid = 1;
            while (!w_ready) @(negedge clk);
            @(negedge clk);
        end
        w_valid = 0; w_last = 0;
        n = 0;
        while (!b_valid && n < 100) begin @(negedge clk); n++; end
        chk("R4 write latency", 32'(n), 32'(WR_LAT));
        chk("R4 bresp okay", 32'(b_resp), 0);
        chk("R4 w_ready low during response", 32'(w_ready), 0);
        @(negedge clk);
        chk("R8 b_valid held without b_ready", 32'(b_valid), 1);
        b_ready = 1;
        @(negedge clk);
        b_ready = 0;
        chk("R7 aw_ready back after response", 32'(aw_ready), 1);
    endtask

    task automatic do_read(input logic [11:0] addr, input logic [7:0] len, input bit stall);
        int n;
        @(negedge clk);
        ar_addr = addr; ar_len = len; ar_valid = 1;
        while (!ar_ready) @(negedge clk);
        @(negedge clk);
        ar_valid = 0;
        n = 0;
        while (!r_valid && n < 100) begin @(negedge clk); n++; end
        chk("R3 read latency", 32'(n), 32'(RD_LAT));
        for (int b = 0; b <= int'(len); b++) begin
            if (stall) begin
                logic [31:0] held;
                logic        held_last;
                held = r_data; held_last = r_last;
                @(negedge clk); @(negedge clk);
                chk("R8 r_valid held", 32'(r_valid), 1);
                chk("R8 r_data stable", r_data, held);
                chk("R8 r_last stable", 32'(r_last), 32'(held_last));
            end
            chk("R2 r_valid on beat", 32'(r_valid), 1);
            chk("R2 r_last position", 32'(r_last), 32'(b == int'(len)));
            chk("R9 rresp okay", 32'(r_resp), 0);
            chk("R7 ar_ready low while reading", 32'(ar_ready), 0);
            got[b] = r_data;
            r_ready = 1;
            @(negedge clk);
            r_ready = 0;
        end
        chk("R2 no beat after last", 32'(r_valid), 0);
        chk("R7 ar_ready back after last beat", 32'(ar_ready), 1);
    endtask

    typedef struct packed {
        logic [11:0] addr;
        logic [7:0]  len;
        logic [31:0] seed;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{12'h000, 8'd3, 32'h1000_0000},
        '{12'h010, 8'd0, 32'h2222_0000},
        '{12'h024, 8'd2, 32'hA5A5_0000},
        '{12'h038, 8'd3, 32'h7700_0000}   // words 14,15,0,1: wraps at the end of the store
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ar_ready in reset", 32'(ar_ready), 1);
        chk("R1 aw_ready in reset", 32'(aw_ready), 1);
        chk("R1 r_valid in reset", 32'(r_valid), 0);
        chk("R1 w_ready in reset", 32'(w_ready), 0);
        chk("R1 b_valid in reset", 32'(b_valid), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ar_ready after reset", 32'(ar_ready), 1);
        chk("R1 aw_ready after reset", 32'(aw_ready), 1);

        // table walk: write a burst, read it back (R2, R3, R4, R7, R9)
        for (int i = 0; i < 4; i++) begin
            do_write(VECS[i].addr, VECS[i].len, VECS[i].seed, 4'hF);
            do_read(VECS[i].addr, VECS[i].len, 1'b0);
            for (int b = 0; b <= int'(VECS[i].len); b++)
                chk("R2 read data", got[b], VECS[i].seed + 32'(b));
        end

        // R5: partial strobes merge with the old word
        do_write(12'h008, 8'd0, 32'h1122_3344, 4'hF);
        do_write(12'h008, 8'd0, 32'hAABB_CCDD, 4'b0101);
        do_read(12'h008, 8'd0, 1'b0);
        chk("R5 byte strobes", got[0], 32'h11BB_33DD);

        // R6: 0x104 and 0x006 both reach word 1; read with back-pressure (R8)
        do_write(12'h104, 8'd0, 32'hCAFE_F00D, 4'hF);
        do_read(12'h006, 8'd0, 1'b1);
        chk("R6 alias and offset ignored", got[0], 32'hCAFE_F00D);

        // R6: word 0 rewritten by the wrapped burst is reachable at 0x040
        do_read(12'h040, 8'd1, 1'b0);
        chk("R6 alias word 0", got[0], 32'h7700_0002);

        // R10, R11: derived width and zero latency on the second instance
        @(negedge clk);
        zaw_addr = 6'h3C; zaw_len = 8'd0; zaw_valid = 1;
        @(negedge clk);
        zaw_valid = 0;
        zw_data = 32'h0BAD_BEEF; zw_strb = 4'hF; zw_last = 1; zw_valid = 1;
        @(negedge clk);
        zw_valid = 0; zw_last = 0;
        chk("R11 zero write latency", 32'(zb_valid), 1);
        zb_ready = 1;
        @(negedge clk);
        zb_ready = 0;
        zar_addr = 6'h3C; zar_len = 8'd0; zar_valid = 1;
        @(negedge clk);
        zar_valid = 0;
        chk("R11 zero read latency", 32'(zr_valid), 1);
        chk("R10 top address reaches last word", zr_data, 32'h0BAD_BEEF);
        zr_ready = 1;
        @(negedge clk);
        zr_ready = 0;
        chk("R10 burst closes", 32'(zr_valid), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule